// File: doc/BRIEF.md
# Event Fragment Link Receiver

This block terminates one serial data link carrying 16-bit words, one per bunch-crossing clock. Each word arrives as a 22-bit single-error-correcting, double-error-detecting code. After decoding, the block follows the fragment structure of the stream: an opening header, any number of payload words, and a closing trailer. It compares every header's event number against a locally kept expected number. When a fragment is missing its header or its trailer, the block inserts a substitute. It then writes the resulting words into an external buffer FIFO through a write port that accepts up to two words per cycle.

The buffer's fill level comes back as an input. Near the top of the buffer, payload is discarded, but headers and trailers are still written, so downstream event building always sees whole fragments. The block keeps running counts of received words, finished events and errors. A header carrying a mark bit copies those counts into a snapshot so that several channels can be compared at the same event boundary. A fast warning output reports a fill level above a programmable limit.

Top module: `lrx_link_rx`

## Requirements
- R1: A received code word with one flipped bit, including the overall parity bit (code bit 0) or a check bit (code bits 1, 2, 4, 8, 16), is corrected and its 16 data bits are passed on unchanged. Data bits occupy, in ascending order, the code positions 1..21 that are not powers of two.
- R2: A word with an uncorrectable error is not written and adds one to the error count.
- R3: Word tag bits [15:14] are 01 for a header, 11 for a trailer, and any other value for payload. A header is written as {01, mark, 0, event[11:0]}. Payload is written unchanged. The block writes each trailer itself as {11, truncated, synthetic, stored payload count[11:0]}.
- R4: A header event number that differs from the expected number adds one to the error count, and the expected number takes the received value. Every trailer, whether real or synthetic, increments the expected number. The expected number is 0 after reset.
- R5: While fifo_level >= FIFO_DEPTH - max(AF_MARGIN,2), payload words are dropped and the fragment's trailer sets its truncated bit. Headers and trailers are still written.
- R6: A payload word or a trailer that arrives outside a fragment is preceded, in the same cycle, by a synthetic header {01,0,1,expected}. This adds one error.
- R7: A header that arrives inside an open fragment is preceded, in the same cycle, by a synthetic trailer for that fragment with its synthetic bit set. This adds one error.
- R8: cnt_words counts every valid input word. cnt_events counts every trailer written. cnt_errors counts every error from R2, R4, R6 and R7.
- R9: A header with mark bit [13] set copies the count values and the expected event number, as they stood before that word, into the snapshot outputs.
- R10: ovf_warn is high exactly while fifo_level > WARN_LEVEL.
- R11: After reset, no words are written and all counters and snapshots are zero.
- R12: Write results appear one clock after the input word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input code word present |
| in_code | input | 22 | Coded input word |
| fifo_level | input | LVL_W | Buffer occupancy |
| wr_cnt | output | 2 | Number of words written this cycle (0..2) |
| wr_word0 | output | 16 | First word written |
| wr_word1 | output | 16 | Second word written |
| ovf_warn | output | 1 | Fill level above the warning limit |
| cnt_words | output | CNT_W | Received word count |
| cnt_events | output | CNT_W | Completed event count |
| cnt_errors | output | CNT_W | Error count |
| snap_words | output | CNT_W | Snapshot of word count |
| snap_events | output | CNT_W | Snapshot of event count |
| snap_errors | output | CNT_W | Snapshot of error count |
| snap_evn | output | 12 | Snapshot of expected event number |

## Verification
The bench builds the block with FIFO_DEPTH=16, AF_MARGIN=2 and WARN_LEVEL=10. With these values the drop threshold (14) and the warning edge (10 to 11) can be reached by driving fifo_level directly. CNT_W=8 keeps the counters small. A table-driven stream covers correction of data, check and parity bits, event-number resync, and both kinds of framing repair. Directed steps then test truncation at and just below the threshold, the warning edge and a marked snapshot.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  localparam int DATA_W = 16;
  localparam int CODE_W = 22;
  localparam logic [1:0] TAG_HDR = 2'b01;
  localparam logic [1:0] TAG_TRL = 2'b11;

  function automatic logic [CODE_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < 5; k++) begin
      for (int p = 1; p < CODE_W; p++) begin
        if (((p & (p - 1)) != 0) && ((p >> k) & 1) == 1) c[1 << k] = c[1 << k] ^ c[p];
      end
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [15:0] mk_header(input logic mark, input logic synth,
                                            input logic [11:0] evn);
    return {TAG_HDR, mark, synth, evn};
  endfunction

  function automatic logic [15:0] mk_trailer(input logic trunc, input logic synth,
                                             input logic [11:0] cnt);
    return {TAG_TRL, trunc, synth, cnt};
  endfunction

  function automatic logic [1:0] err_sum(input logic a, input logic b,
                                         input logic c, input logic d);
    return 2'({1'b0, a} + {1'b0, b} + {1'b0, c} + {1'b0, d});
  endfunction
endpackage

// File: rtl/lrx_secded_dec.sv
module lrx_secded_dec
  import lrx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              corrected,
  output logic              bad
);
  logic [4:0]        syn;
  logic              par;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (code[p]) syn = syn ^ 5'(p);
    end
    par = ^code;
    fixed = code;
    corrected = 1'b0;
    bad = 1'b0;
    if (par) begin
      if (syn == 5'd0) corrected = 1'b1;
      else if (int'(syn) < CODE_W) begin
        fixed[syn] = ~code[syn];
        corrected = 1'b1;
      end else bad = 1'b1;
    end else if (syn != 5'd0) bad = 1'b1;
    data = '0;
    begin
      int j;
      j = 0;
      for (int p = 1; p < CODE_W; p++) begin
        if ((p & (p - 1)) != 0) begin
          data[j] = fixed[p];
          j++;
        end
      end
    end
  end
endmodule

// File: rtl/lrx_framer.sv
module lrx_framer
  import lrx_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int AF_LIMIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] dec_word,
  input  logic              dec_bad,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic [1:0]        wr_cnt,
  output logic [15:0]       wr_word0,
  output logic [15:0]       wr_word1,
  output logic [11:0]       exp_evn,
  output logic              open_q,
  output logic              full,
  output logic              ev_uncorr,
  output logic              ev_mismatch,
  output logic              ev_miss_hdr,
  output logic              ev_miss_trl,
  output logic              ev_trailer,
  output logic              ev_mark,
  output logic              ev_drop
);
  logic [11:0] pay_cnt, n_pc, n_exp, base;
  logic        trunc_q, n_tr, n_open;
  logic [1:0]  n_cnt;
  logic [15:0] n_w0, n_w1;

  assign full = (int'(fifo_level) >= AF_LIMIT);

  always_comb begin
    n_cnt = 2'd0; n_w0 = '0; n_w1 = '0;
    n_open = open_q; n_pc = pay_cnt; n_tr = trunc_q; n_exp = exp_evn; base = exp_evn;
    ev_uncorr = 1'b0; ev_mismatch = 1'b0; ev_miss_hdr = 1'b0; ev_miss_trl = 1'b0;
    ev_trailer = 1'b0; ev_mark = 1'b0; ev_drop = 1'b0;
    if (in_valid) begin
      if (dec_bad) ev_uncorr = 1'b1;
      else if (dec_word[15:14] == TAG_HDR) begin
        if (open_q) begin
          n_w0 = mk_trailer(trunc_q, 1'b1, pay_cnt);
          n_cnt = 2'd1;
          ev_miss_trl = 1'b1;
          ev_trailer = 1'b1;
          base = exp_evn + 12'd1;
        end
        if (n_cnt == 2'd0) n_w0 = mk_header(dec_word[13], 1'b0, dec_word[11:0]);
        else n_w1 = mk_header(dec_word[13], 1'b0, dec_word[11:0]);
        n_cnt = n_cnt + 2'd1;
        ev_mismatch = (dec_word[11:0] != base);
        ev_mark = dec_word[13];
        n_exp = dec_word[11:0];
        n_open = 1'b1; n_pc = '0; n_tr = 1'b0;
      end else if (dec_word[15:14] == TAG_TRL) begin
        if (!open_q) begin
          n_w0 = mk_header(1'b0, 1'b1, exp_evn);
          n_cnt = 2'd1;
          ev_miss_hdr = 1'b1;
        end
        if (n_cnt == 2'd0) n_w0 = mk_trailer(trunc_q, 1'b0, pay_cnt);
        else n_w1 = mk_trailer(trunc_q, 1'b0, pay_cnt);
        n_cnt = n_cnt + 2'd1;
        ev_trailer = 1'b1;
        n_exp = exp_evn + 12'd1;
        n_open = 1'b0; n_pc = '0; n_tr = 1'b0;
      end else begin
        if (!open_q) begin
          n_w0 = mk_header(1'b0, 1'b1, exp_evn);
          n_cnt = 2'd1;
          ev_miss_hdr = 1'b1;
        end
        if (full) begin
          ev_drop = 1'b1;
          n_tr = 1'b1;
        end else begin
          if (n_cnt == 2'd0) n_w0 = dec_word;
          else n_w1 = dec_word;
          n_cnt = n_cnt + 2'd1;
          n_pc = pay_cnt + 12'd1;
        end
        n_open = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= 2'd0; wr_word0 <= '0; wr_word1 <= '0;
      exp_evn <= '0; open_q <= 1'b0; pay_cnt <= '0; trunc_q <= 1'b0;
    end else begin
      wr_cnt <= n_cnt; wr_word0 <= n_w0; wr_word1 <= n_w1;
      exp_evn <= n_exp; open_q <= n_open; pay_cnt <= n_pc; trunc_q <= n_tr;
    end
  end
endmodule

// File: rtl/lrx_monitor.sv
module lrx_monitor
  import lrx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             ev_uncorr,
  input  logic             ev_mismatch,
  input  logic             ev_miss_hdr,
  input  logic             ev_miss_trl,
  input  logic             ev_trailer,
  input  logic             ev_mark,
  input  logic [11:0]      exp_evn,
  output logic [CNT_W-1:0] cnt_words,
  output logic [CNT_W-1:0] cnt_events,
  output logic [CNT_W-1:0] cnt_errors,
  output logic [CNT_W-1:0] snap_words,
  output logic [CNT_W-1:0] snap_events,
  output logic [CNT_W-1:0] snap_errors,
  output logic [11:0]      snap_evn
);
  logic [1:0] err_inc;
  assign err_inc = err_sum(ev_uncorr, ev_mismatch, ev_miss_hdr, ev_miss_trl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_words <= '0; cnt_events <= '0; cnt_errors <= '0;
      snap_words <= '0; snap_events <= '0; snap_errors <= '0; snap_evn <= '0;
    end else begin
      if (in_valid) cnt_words <= cnt_words + 1'b1;
      if (ev_trailer) cnt_events <= cnt_events + 1'b1;
      cnt_errors <= cnt_errors + CNT_W'(err_inc);
      if (ev_mark) begin
        snap_words <= cnt_words; snap_events <= cnt_events;
        snap_errors <= cnt_errors; snap_evn <= exp_evn;
      end
    end
  end
endmodule

// File: rtl/lrx_link_rx.sv
module lrx_link_rx
  import lrx_pkg::*;
#(
  parameter int FIFO_DEPTH = 1024,
  parameter int AF_MARGIN  = 4,
  parameter int WARN_LEVEL = 768,
  parameter int CNT_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int AF_LIMIT  = FIFO_DEPTH - ((AF_MARGIN < 2) ? 2 : AF_MARGIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [21:0]       in_code,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic [1:0]        wr_cnt,
  output logic [15:0]       wr_word0,
  output logic [15:0]       wr_word1,
  output logic              ovf_warn,
  output logic [CNT_W-1:0]  cnt_words,
  output logic [CNT_W-1:0]  cnt_events,
  output logic [CNT_W-1:0]  cnt_errors,
  output logic [CNT_W-1:0]  snap_words,
  output logic [CNT_W-1:0]  snap_events,
  output logic [CNT_W-1:0]  snap_errors,
  output logic [11:0]       snap_evn
);
  logic [15:0] dec_word;
  logic        dec_corr, dec_bad, open_q, full;
  logic        ev_uncorr, ev_mismatch, ev_miss_hdr, ev_miss_trl, ev_trailer, ev_mark, ev_drop;
  logic [11:0] exp_evn;

  lrx_secded_dec u_dec (.code(in_code), .data(dec_word), .corrected(dec_corr), .bad(dec_bad));

  lrx_framer #(.LVL_W(LVL_W), .AF_LIMIT(AF_LIMIT)) u_frm (
    .clk, .rst_n, .in_valid, .dec_word, .dec_bad, .fifo_level,
    .wr_cnt, .wr_word0, .wr_word1, .exp_evn, .open_q, .full,
    .ev_uncorr, .ev_mismatch, .ev_miss_hdr, .ev_miss_trl, .ev_trailer, .ev_mark, .ev_drop);

  lrx_monitor #(.CNT_W(CNT_W)) u_mon (
    .clk, .rst_n, .in_valid, .ev_uncorr, .ev_mismatch, .ev_miss_hdr, .ev_miss_trl,
    .ev_trailer, .ev_mark, .exp_evn, .cnt_words, .cnt_events, .cnt_errors,
    .snap_words, .snap_events, .snap_errors, .snap_evn);

  assign ovf_warn = (int'(fifo_level) > WARN_LEVEL);
endmodule

// File: rtl/lrx_link_rx_chk.sv
module lrx_link_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             dec_bad,
  input logic [15:0]      dec_word,
  input logic             open_q,
  input logic             full,
  input logic             ev_miss_hdr,
  input logic             ev_miss_trl,
  input logic             ev_mark,
  input logic [1:0]       wr_cnt,
  input logic [15:0]      wr_word0,
  input logic [15:0]      wr_word1,
  input logic [CNT_W-1:0] cnt_words,
  input logic [CNT_W-1:0] cnt_events,
  input logic [CNT_W-1:0] snap_words
);
  p_uncorr_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_bad) |=> (wr_cnt == 2'd0));

  p_drop_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_bad && open_q && full && dec_word[15:14] != 2'b01 &&
     dec_word[15:14] != 2'b11) |=> (wr_cnt == 2'd0));

  p_miss_hdr_synth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss_hdr |=> (wr_cnt != 2'd0 && wr_word0[15:14] == 2'b01 && wr_word0[12]));

  p_miss_trl_synth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss_trl |=> (wr_cnt == 2'd2 && wr_word0[15:14] == 2'b11 && wr_word0[12] &&
                     wr_word1[15:14] == 2'b01));

  p_word_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cnt_words == $past(cnt_words) + 1'b1));

  p_event_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (cnt_events == $past(cnt_events) || cnt_events == $past(cnt_events) + 1'b1));

  p_snap_words_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mark |=> (snap_words == $past(cnt_words)));
endmodule

bind lrx_link_rx lrx_link_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_bad(dec_bad), .dec_word(dec_word),
  .open_q(open_q), .full(full), .ev_miss_hdr(ev_miss_hdr), .ev_miss_trl(ev_miss_trl),
  .ev_mark(ev_mark), .wr_cnt(wr_cnt), .wr_word0(wr_word0), .wr_word1(wr_word1),
  .cnt_words(cnt_words), .cnt_events(cnt_events), .snap_words(snap_words));

// File: tb/test_lrx_link_rx.sv
module test_lrx_link_rx;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = 8;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [21:0] in_code = '0;
  logic [LW-1:0] fifo_level = '0;
  logic [1:0] wr_cnt;
  logic [15:0] wr_word0, wr_word1;
  logic ovf_warn;
  logic [CW-1:0] cnt_words, cnt_events, cnt_errors, snap_words, snap_events, snap_errors;
  logic [11:0] snap_evn;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lrx_link_rx #(.FIFO_DEPTH(DEPTH), .AF_MARGIN(2), .WARN_LEVEL(10), .CNT_W(CW)) i_lrx_link_rx (
    .clk, .rst_n, .in_valid, .in_code, .fifo_level, .wr_cnt, .wr_word0, .wr_word1,
    .ovf_warn, .cnt_words, .cnt_events, .cnt_errors, .snap_words, .snap_events,
    .snap_errors, .snap_evn);

  // fields: data[71:56] flip mask[55:34] wr_cnt[33:32] word0[31:16] word1[15:0]
  localparam logic [71:0] VEC [NV] = '{
    {16'h4000, 22'h0,  2'd1, 16'h4000, 16'h0},     // R3 header evn 0
    {16'hAABC, 22'h0,  2'd1, 16'hAABC, 16'h0},     // R3 payload
    {16'h8123, 22'h20, 2'd1, 16'h8123, 16'h0},     // R1 data bit flip
    {16'hC0FF, 22'h0,  2'd1, 16'hC002, 16'h0},     // R3 trailer count 2
    {16'h4001, 22'h1,  2'd1, 16'h4001, 16'h0},     // R1 parity bit flip
    {16'hC000, 22'h0,  2'd1, 16'hC000, 16'h0},
    {16'h4005, 22'h0,  2'd1, 16'h4005, 16'h0},     // R4 mismatch, resync
    {16'hC000, 22'h0,  2'd1, 16'hC000, 16'h0},
    {16'h8001, 22'h0,  2'd2, 16'h5006, 16'h8001},  // R6 missing header
    {16'h4007, 22'h0,  2'd2, 16'hD001, 16'h4007},  // R7 missing trailer
    {16'hC000, 22'h10, 2'd1, 16'hC000, 16'h0},     // R1 check bit flip
    {16'hC000, 22'h0,  2'd2, 16'h5008, 16'hC000},  // R6 trailer with no header
    {16'h4009, 22'h6,  2'd0, 16'h0,    16'h0}      // R2 double error
  };

  function automatic logic [21:0] code_of(input logic [15:0] d);
    logic [21:0] c;
    logic [4:0] s;
    int k;
    c = '0; k = 0; s = '0;
    for (int p = 3; p < 22; p++) begin
      if (p != 4 && p != 8 && p != 16) begin
        c[p] = d[k];
        if (d[k]) s = s ^ 5'(p);
        k++;
      end
    end
    c[1] = s[0]; c[2] = s[1]; c[4] = s[2]; c[8] = s[3]; c[16] = s[4];
    c[0] = ^c[21:1];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input logic [21:0] flip);
    @(negedge clk);
    in_valid = 1'b1;
    in_code = code_of(d) ^ flip;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 wr_cnt", 32'(wr_cnt), 0);
    check("R11 cnt_words", 32'(cnt_words), 0);
    check("R11 cnt_errors", 32'(cnt_errors), 0);
    check("R11 snap_words", 32'(snap_words), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11 idle after reset", 32'(wr_cnt), 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][71:56], VEC[i][55:34]);
      check($sformatf("R12 vec%0d wr_cnt", i), 32'(wr_cnt), 32'(VEC[i][33:32]));
      if (VEC[i][33:32] != 2'd0) check($sformatf("R3 vec%0d word0", i), 32'(wr_word0), 32'(VEC[i][31:16]));
      if (VEC[i][33:32] == 2'd2) check($sformatf("R6 R7 vec%0d word1", i), 32'(wr_word1), 32'(VEC[i][15:0]));
    end
    idle();
    @(posedge clk); #1;
    check("R12 no input no write", 32'(wr_cnt), 0);
    check("R8 words", 32'(cnt_words), 13);
    check("R8 events", 32'(cnt_events), 6);
    check("R8 R2 R4 errors", 32'(cnt_errors), 5);

    fifo_level = LW'(14);
    send(16'h4009, 22'h0);
    check("R5 header at threshold", 32'(wr_word0), 32'h4009);
    send(16'h8055, 22'h0);
    check("R5 payload dropped", 32'(wr_cnt), 0);
    fifo_level = LW'(13);
    send(16'h8066, 22'h0);
    check("R5 below threshold kept", 32'(wr_word0), 32'h8066);
    fifo_level = LW'(14);
    send(16'hC000, 22'h0);
    check("R5 trailer truncated", 32'(wr_word0), 32'hE001);
    idle();

    fifo_level = LW'(10);
    #1 check("R10 at limit", 32'(ovf_warn), 0);
    fifo_level = LW'(11);
    #1 check("R10 above limit", 32'(ovf_warn), 1);
    fifo_level = '0;

    send(16'h600A, 22'h0);
    check("R9 marked header", 32'(wr_word0), 32'h600A);
    check("R9 snap words", 32'(snap_words), 17);
    check("R9 snap events", 32'(snap_events), 7);
    check("R9 snap errors", 32'(snap_errors), 5);
    check("R9 snap evn", 32'(snap_evn), 10);
    idle();
    @(posedge clk); #1;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule